// File: doc/BRIEF.md
# Wake and Interrupt Status Controller

This block is the power-management status unit of a peripheral controller. It runs a two-state machine that puts the system either in a sleeping state or in a working state. It also holds a wake flag that records why the system woke up. Enabled resume events set the wake flag while the system sleeps. Setting the flag moves the machine to working on the same clock edge. An expiry pulse from an external global standby timer sends the machine back to sleeping and clears the flag at the same edge.

Two interrupt-status registers capture single-cycle pulses from their sources. The device register has four sources: printer port, floppy controller, UART A and UART B. The function register has four others: hardware monitor, watchdog timer, consumer IR and MIDI. Software reads and clears every flag through a simple register port. Writing 1 to a bit clears it. Each status register drives a summary interrupt output.

The states are `ST_SLEEP` and `ST_WORK`. There are two transitions. `WAKE_UP` goes from `ST_SLEEP` to `ST_WORK` on an enabled resume event. `STANDBY` goes from `ST_WORK` to `ST_SLEEP` on timer expiry. In every other case the machine holds its state.

Top module: `pm_wake_status`

## Requirements
- R1: After reset the machine is in `ST_SLEEP`, the wake flag is 0, and every register reads 0x00.
- R2: The wake flag is set only by hardware, and only in `ST_SLEEP`. It is set when some bit of `resume_evt` is high while the matching bit of `resume_en` is high. A resume event whose enable is low is ignored. Resume events in `ST_WORK` are ignored.
- R3: The clock edge that sets the wake flag also moves the machine from `ST_SLEEP` to `ST_WORK` (the `WAKE_UP` transition). The `working` output is 1 in `ST_WORK` and 0 in `ST_SLEEP`. Address 0 shows the state in bit 0 and the wake flag in bit 7. Bits 6..1 of address 0 read 0.
- R4: A write to address 0 with data bit 7 set clears the wake flag. A write to address 0 with bit 7 clear leaves the flag unchanged. A software write never changes the state.
- R5: When `standby_expire` is high in `ST_WORK`, the next edge takes the machine to `ST_SLEEP` and clears the wake flag (the `STANDBY` transition). When `standby_expire` is high in `ST_SLEEP`, the state does not change.
- R6: The device interrupt register is at address 1. Bit 3 is the printer port, bit 2 the floppy controller, bit 1 UART A and bit 0 UART B. A pulse on `dev_irq_pulse[i]` sets bit i at the next edge.
- R7: The function interrupt register is at address 2. Bit 3 is the hardware monitor, bit 2 the watchdog timer, bit 1 consumer IR and bit 0 MIDI. A pulse on `fn_irq_pulse[i]` sets bit i at the next edge.
- R8: Writing 1 to bit i of an interrupt register clears that bit. Writing 0 to a bit leaves it unchanged.
- R9: If a source pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: Bits 7..4 of both interrupt registers always read 0. Address 3 reads 0x00.
- R11: `dev_irq` is high exactly when some bit of the device register is set. `fn_irq` is high exactly when some bit of the function register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address; it also selects the read data |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| dev_irq_pulse | input | 4 | Device interrupt pulses (printer, floppy, UART A, UART B) |
| fn_irq_pulse | input | 4 | Function interrupt pulses (hw monitor, watchdog, CIR, MIDI) |
| resume_evt | input | 4 | Resume event inputs |
| resume_en | input | 4 | Enable mask for resume events |
| standby_expire | input | 1 | Expiry pulse from the global standby timer |
| working | output | 1 | 1 in `ST_WORK`, 0 in `ST_SLEEP` |
| dev_irq | output | 1 | Summary of the device interrupt register |
| fn_irq | output | 1 | Summary of the function interrupt register |

## Verification
The assertions are checked on every cycle. They cover these rules:
- The wake flag rises only after an enabled resume event in `ST_SLEEP`, and always together with entry to `ST_WORK`.
- `STANDBY` leaves the machine sleeping with the flag clear.
- A pulse always lands in its status bit, even when a clear hits the same bit.
- A write of zeros leaves the interrupt bits unchanged.
- The reserved bits stay zero.

Some behaviours show only in the bench's scenarios. These are the exact bit positions of each source, the reset contents, software clears of the wake flag, and expiry while sleeping. The bench also covers long random mixes of writes, pulses and resume events that a per-cycle model must follow.

// File: rtl/pm_wake_pkg.sv
`timescale 1ns/1ps
package pm_wake_pkg;

    localparam int REG_W    = 8;
    localparam int WAKE_BIT = 7;

    typedef enum logic {
        ST_SLEEP = 1'b0,
        ST_WORK  = 1'b1
    } pm_state_e;

endpackage

// File: rtl/pm_sleep_fsm.sv
`timescale 1ns/1ps
module pm_sleep_fsm
    import pm_wake_pkg::*;
#(
    parameter int NRES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NRES-1:0] resume_evt,
    input  logic [NRES-1:0] resume_en,
    input  logic            standby_expire,
    input  logic            sw_clr_wake,
    output pm_state_e       state,
    output logic            wake_q
);

    pm_state_e state_nx;
    logic      wake_nx;
    logic      resume_hit;

    assign resume_hit = |(resume_evt & resume_en);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_SLEEP;
            wake_q <= 1'b0;
        end else begin
            state  <= state_nx;
            wake_q <= wake_nx;
        end
    end

    // Transitions and wake flag
    always_comb begin
        state_nx = state;
        wake_nx  = wake_q;
        unique case (state)
            ST_SLEEP: begin
                if (resume_hit) begin
                    // WAKE_UP: hardware set wins over a software clear
                    state_nx = ST_WORK;
                    wake_nx  = 1'b1;
                end else if (sw_clr_wake) begin
                    wake_nx = 1'b0;
                end
            end
            ST_WORK: begin
                if (standby_expire) begin
                    // STANDBY: return to sleep and drop the wake flag
                    state_nx = ST_SLEEP;
                    wake_nx  = 1'b0;
                end else if (sw_clr_wake) begin
                    wake_nx = 1'b0;
                end
            end
            default: begin
                state_nx = ST_SLEEP;
                wake_nx  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pm_irq_status.sv
`timescale 1ns/1ps
module pm_irq_status #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic            clr_en,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    logic [NSRC-1:0] clr_bits;

    assign clr_bits = clr_en ? clr_mask : '0;

    genvar b;
    generate
        for (b = 0; b < NSRC; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status[b] <= 1'b0;
                else if (src_pulse[b])
                    status[b] <= 1'b1;      // set wins over clear
                else if (clr_bits[b])
                    status[b] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |status;

endmodule

// File: rtl/pm_reg_rdmux.sv
`timescale 1ns/1ps
module pm_reg_rdmux
    import pm_wake_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int NSRC     = 4,
    parameter int CTL_ADDR = 0,
    parameter int DEV_ADDR = 1,
    parameter int FN_ADDR  = 2
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wake_q,
    input  logic              working,
    input  logic [NSRC-1:0]   dev_status,
    input  logic [NSRC-1:0]   fn_status,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int PAD_W = REG_W - NSRC;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTL_ADDR)) begin
            reg_rdata[WAKE_BIT] = wake_q;
            reg_rdata[0]        = working;
        end else if (reg_addr == ADDR_W'(DEV_ADDR)) begin
            reg_rdata = {{PAD_W{1'b0}}, dev_status};
        end else if (reg_addr == ADDR_W'(FN_ADDR)) begin
            reg_rdata = {{PAD_W{1'b0}}, fn_status};
        end
    end

endmodule

// File: rtl/pm_wake_status.sv
`timescale 1ns/1ps
module pm_wake_status
    import pm_wake_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int NRES   = 4,
    parameter int NSRC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NSRC-1:0]   dev_irq_pulse,
    input  logic [NSRC-1:0]   fn_irq_pulse,
    input  logic [NRES-1:0]   resume_evt,
    input  logic [NRES-1:0]   resume_en,
    input  logic              standby_expire,
    output logic              working,
    output logic              dev_irq,
    output logic              fn_irq
);

    localparam int CTL_ADDR = 0;
    localparam int DEV_ADDR = 1;
    localparam int FN_ADDR  = 2;
    localparam int NREG     = 2;

    pm_state_e state;
    logic      wake_q;
    logic      sw_clr_wake;

    logic [NREG-1:0][NSRC-1:0] pulses;
    logic [NREG-1:0][NSRC-1:0] stat;
    logic [NREG-1:0]           irqs;
    logic [NSRC-1:0]           dev_status;
    logic [NSRC-1:0]           fn_status;

    assign sw_clr_wake = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR)) && reg_wdata[WAKE_BIT];

    pm_sleep_fsm #(.NRES(NRES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .resume_evt     (resume_evt),
        .resume_en      (resume_en),
        .standby_expire (standby_expire),
        .sw_clr_wake    (sw_clr_wake),
        .state          (state),
        .wake_q         (wake_q)
    );

    assign pulses[0] = dev_irq_pulse;
    assign pulses[1] = fn_irq_pulse;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_irq
            logic clr_en_r;
            assign clr_en_r = reg_wr && (reg_addr == ADDR_W'(DEV_ADDR + r));
            pm_irq_status #(.NSRC(NSRC)) u_stat (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_pulse (pulses[r]),
                .clr_en    (clr_en_r),
                .clr_mask  (reg_wdata[NSRC-1:0]),
                .status    (stat[r]),
                .irq       (irqs[r])
            );
        end
    endgenerate

    assign dev_status = stat[0];
    assign fn_status  = stat[1];
    assign dev_irq    = irqs[0];
    assign fn_irq     = irqs[1];
    assign working    = (state == ST_WORK);

    pm_reg_rdmux #(
        .ADDR_W   (ADDR_W),
        .NSRC     (NSRC),
        .CTL_ADDR (CTL_ADDR),
        .DEV_ADDR (DEV_ADDR),
        .FN_ADDR  (FN_ADDR)
    ) u_rdmux (
        .reg_addr   (reg_addr),
        .wake_q     (wake_q),
        .working    (working),
        .dev_status (dev_status),
        .fn_status  (fn_status),
        .reg_rdata  (reg_rdata)
    );

endmodule

// File: rtl/pm_wake_status_chk.sv
`timescale 1ns/1ps
module pm_wake_status_chk #(
    parameter int ADDR_W = 2,
    parameter int NRES   = 4,
    parameter int NSRC   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [NSRC-1:0]   dev_irq_pulse,
    input logic [NSRC-1:0]   fn_irq_pulse,
    input logic [NRES-1:0]   resume_evt,
    input logic [NRES-1:0]   resume_en,
    input logic              standby_expire,
    input logic              working,
    input logic              dev_irq,
    input logic              fn_irq,
    input logic              wake_q,
    input logic [NSRC-1:0]   dev_status,
    input logic [NSRC-1:0]   fn_status
);

    assert_wake_only_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> ($past(!working) && $past(|(resume_evt & resume_en))));

    assert_wake_enters_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> working);

    assert_standby_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (working && standby_expire) |=> (!working && !wake_q));

    assert_dev_write0_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[NSRC-1:0] == '0 && dev_irq_pulse == '0)
        |=> $stable(dev_status));

    assert_dev_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_irq_pulse) |=> ((dev_status & $past(dev_irq_pulse)) == $past(dev_irq_pulse)));

    assert_fn_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fn_irq_pulse) |=> ((fn_status & $past(fn_irq_pulse)) == $past(fn_irq_pulse)));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2)) |-> (reg_rdata[7:4] == 4'h0));

    assert_dev_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_irq) |-> $past(|dev_irq_pulse));

    assert_fn_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fn_irq) |-> $past(|fn_irq_pulse));

endmodule

bind pm_wake_status pm_wake_status_chk #(
    .ADDR_W (ADDR_W),
    .NRES   (NRES),
    .NSRC   (NSRC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .dev_irq_pulse  (dev_irq_pulse),
    .fn_irq_pulse   (fn_irq_pulse),
    .resume_evt     (resume_evt),
    .resume_en      (resume_en),
    .standby_expire (standby_expire),
    .working        (working),
    .dev_irq        (dev_irq),
    .fn_irq         (fn_irq),
    .wake_q         (wake_q),
    .dev_status     (dev_status),
    .fn_status      (fn_status)
);

// File: tb/pm_wake_status_tb.sv
`timescale 1ns/1ps
module pm_wake_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] dev_irq_pulse = '0;
    logic [3:0] fn_irq_pulse = '0;
    logic [3:0] resume_evt = '0;
    logic [3:0] resume_en = '0;
    logic       standby_expire = 1'b0;
    logic       working, dev_irq, fn_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit       m_work;
    bit       m_wake;
    bit [3:0] m_dev;
    bit [3:0] m_fn;

    always #5 clk = ~clk;

    pm_wake_status u_dut (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .dev_irq_pulse (dev_irq_pulse), .fn_irq_pulse (fn_irq_pulse),
        .resume_evt (resume_evt), .resume_en (resume_en),
        .standby_expire (standby_expire), .working (working),
        .dev_irq (dev_irq), .fn_irq (fn_irq)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_wake, 6'b0, m_work};
            2'd1:    return {4'b0, m_dev};
            2'd2:    return {4'b0, m_fn};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge: compare every observable output with the model
    task automatic check_all();
        reg_wr = 1'b0;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            case (a)
                0: chk("R4 wake/state register", reg_rdata, exp_read(2'(a)));
                1: chk("R6 device register", reg_rdata, exp_read(2'(a)));
                2: chk("R7 function register", reg_rdata, exp_read(2'(a)));
                default: chk("R10 unmapped address", reg_rdata, exp_read(2'(a)));
            endcase
        end
        chk("R3 working output", {7'b0, working}, {7'b0, m_work});
        chk("R11 dev_irq", {7'b0, dev_irq}, {7'b0, |m_dev});
        chk("R11 fn_irq", {7'b0, fn_irq}, {7'b0, |m_fn});
    endtask

    // Apply one cycle of stimulus (from negedge), update model at posedge
    task automatic cycle(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                         input logic [3:0] dp, input logic [3:0] fp,
                         input logic [3:0] ev, input logic [3:0] en, input logic ex);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        dev_irq_pulse = dp; fn_irq_pulse = fp;
        resume_evt = ev; resume_en = en; standby_expire = ex;
        @(posedge clk);
        if (!m_work) begin
            if (|(ev & en)) begin m_work = 1'b1; m_wake = 1'b1; end
            else if (wr && a == 2'd0 && wd[7]) m_wake = 1'b0;
        end else begin
            if (ex) begin m_work = 1'b0; m_wake = 1'b0; end
            else if (wr && a == 2'd0 && wd[7]) m_wake = 1'b0;
        end
        m_dev = (m_dev & ~((wr && a == 2'd1) ? wd[3:0] : 4'h0)) | dp;
        m_fn  = (m_fn  & ~((wr && a == 2'd2) ? wd[3:0] : 4'h0)) | fp;
        @(negedge clk);
        reg_wr = 1'b0; dev_irq_pulse = '0; fn_irq_pulse = '0;
        resume_evt = '0; standby_expire = 1'b0;
        check_all();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_work = 0; m_wake = 0; m_dev = 0; m_fn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        reg_addr = 2'd0; #1; chk("R1 reset ctl", reg_rdata, 8'h00);
        reg_addr = 2'd1; #1; chk("R1 reset dev", reg_rdata, 8'h00);
        reg_addr = 2'd2; #1; chk("R1 reset fn", reg_rdata, 8'h00);
        chk("R1 reset working", {7'b0, working}, 8'h00);
        @(negedge clk);

        // R2: disabled resume event is ignored
        cycle(0, 0, 0, 0, 0, 4'hF, 4'h0, 0);
        chk("R2 disabled resume ignored", {7'b0, working}, 8'h00);
        // R2 R3: enabled event wakes, flag and state on same edge
        cycle(0, 0, 0, 0, 0, 4'h4, 4'h4, 0);
        reg_addr = 2'd0; #1;
        chk("R3 wake up register", reg_rdata, 8'h81);
        // R4: write 0 at bit 7 keeps flag; write 1 clears, state stays
        cycle(1, 0, 8'h7F, 0, 0, 0, 0, 0);
        reg_addr = 2'd0; #1; chk("R4 write0 keeps wake", reg_rdata, 8'h81);
        cycle(1, 0, 8'h80, 0, 0, 0, 0, 0);
        reg_addr = 2'd0; #1; chk("R4 clear wake keeps state", reg_rdata, 8'h01);
        // R2: resume in working is ignored
        cycle(0, 0, 0, 0, 0, 4'hF, 4'hF, 0);
        reg_addr = 2'd0; #1; chk("R2 resume in work ignored", reg_rdata, 8'h01);
        // R5: standby in work
        cycle(0, 0, 0, 0, 0, 4'h1, 4'h1, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 1);
        reg_addr = 2'd0; #1; chk("R5 standby to sleep", reg_rdata, 8'h00);
        cycle(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 expire while sleeping", {7'b0, working}, 8'h00);
        // R6 R7: bit positions
        cycle(0, 0, 0, 4'h8, 4'h1, 0, 0, 0);
        reg_addr = 2'd1; #1; chk("R6 printer bit 3", reg_rdata, 8'h08);
        reg_addr = 2'd2; #1; chk("R7 MIDI bit 0", reg_rdata, 8'h01);
        // R8: write 0 has no effect, write 1 clears
        cycle(1, 1, 8'hF0, 0, 0, 0, 0, 0);
        reg_addr = 2'd1; #1; chk("R8 write0 no effect", reg_rdata, 8'h08);
        cycle(1, 1, 8'h08, 0, 0, 0, 0, 0);
        reg_addr = 2'd1; #1; chk("R8 write1 clears", reg_rdata, 8'h00);
        // R9: set and clear same cycle
        cycle(1, 2, 8'h04, 0, 4'h4, 0, 0, 0);
        reg_addr = 2'd2; #1; chk("R9 set wins", reg_rdata, 8'h05);
        chk("R11 fn_irq high", {7'b0, fn_irq}, 8'h01);
        cycle(1, 2, 8'hFF, 0, 0, 0, 0, 0);
        chk("R11 fn_irq low after clear", {7'b0, fn_irq}, 8'h00);
        // R2: set wins over software clear of wake in sleep
        cycle(1, 0, 8'h80, 0, 0, 4'h2, 4'h2, 0);
        reg_addr = 2'd0; #1; chk("R2 wake set beats clear", reg_rdata, 8'h81);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic wr;
            logic [1:0] a;
            logic [7:0] wd;
            logic [3:0] dp, fp, ev, en;
            logic ex;
            wr = ($urandom % 4) == 0;
            a  = 2'($urandom);
            wd = 8'($urandom);
            dp = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
            fp = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
            ev = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            en = 4'($urandom);
            ex = ($urandom % 8) == 0;
            cycle(wr, a, wd, dp, fp, ev, en, ex);
        end
        done = 1'b1;
        finish_run();
    end

endmodule